// File: doc/BRIEF.md
# Multi-mode DSSS chip spreader

This block spreads a stream of data bits into a serial stream of pseudo-noise chips. One chip is produced for each chip-rate strobe. The nominal strobe rate is 1 MHz. The spreading code is a 64-chip word held in a shadow register, which can be written at any time. A symbol only uses the shadow after it is copied into the active code at a symbol boundary.

The block has three runtime spreading modes, all at the same chip rate:

- **64-chip mode:** one bit is spread over all 64 chips, giving 15.625 kbit/s. This is the most robust mode.
- **32-chip mode:** one bit is spread over the upper 32 chips of the code, giving 31.25 kbit/s.
- **Paired mode:** two bits share one 32-chip symbol, giving 62.5 kbit/s. The first bit chooses the code half and the second bit chooses the polarity.

Data is offered on a two-bit valid/take port. The block takes a new symbol's data only on the strobe that follows the last chip of the current symbol. If no data is offered at that point, the block emits idle chips and raises an underrun flag until data returns.

Top module: `dsss_spreader`

## Requirements
- R1: After reset `chip_out` is 0, `underrun` is 0 and `din_take` is 0.
- R2: `chip_out` and `underrun` change only on a clock edge where `chip_en` is high; in every other cycle they hold their value.
- R3: With `mode`=2'b00 (and the reserved value 2'b11, which behaves the same way), one symbol is 64 strobes long. On the strobe that fetches the symbol, `chip_out` takes active-code bit 63, and each later strobe steps one bit lower, down to bit 0. Data bit `din[0]`=1 sends the code as stored and `din[0]`=0 sends it inverted.
- R4: With `mode`=2'b01, one symbol is 32 strobes long. The chips are bits 63 down to 32 of the active code, with the same polarity rule on `din[0]` as in R3.
- R5: With `mode`=2'b10 (paired mode), one symbol is 32 strobes long.
  - `din[1]` is the first bit of the pair. When it is 1 the chips are code bits 63..32; when it is 0 they are bits 31..0. Either half is sent most significant bit first.
  - `din[0]` is the second bit. When it is 1 the half is sent as stored; when it is 0 the half is sent inverted.
- R6: `din_take` is high, in the same cycle and without a register, exactly when `chip_en` and `din_valid` are both high at a symbol boundary. A symbol boundary is either the idle state or the last strobe of the current symbol. `din_take` is high on no other cycle.
- R7: `mode` is sampled only on a fetching strobe. Changing `mode` in the middle of a symbol changes neither that symbol's chips nor its length.
- R8: `code_load` writes `code_in` into the shadow register on any clock edge. A symbol fetched on a later edge uses the new shadow value; a symbol already running keeps its code.
- R9: A strobe at a symbol boundary with `din_valid` low sets `underrun` to 1 and `chip_out` to 0. Every strobe keeps this idle output until a fetch happens, and the fetching strobe clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip-rate strobe, one chip per high cycle |
| mode | input | 2 | 00: 64-chip, 01: 32-chip, 10: paired, 11: same as 00 |
| din_valid | input | 1 | Data for the next symbol is offered |
| din | input | 2 | din[0] polarity bit; din[1] half select in paired mode |
| din_take | output | 1 | Offered data consumed on this edge |
| code_load | input | 1 | Write `code_in` into the shadow code register |
| code_in | input | 64 | New spreading code word |
| chip_out | output | 1 | Current chip |
| underrun | output | 1 | Idle chips are being sent because data was missing |

## Verification
`din_take` is combinational, so the bench checks it 1 ns after driving inputs at the falling edge, before the rising edge that consumes the data. `chip_out` and `underrun` pass through one register. The bench therefore checks them at the falling edge right after each rising edge, against a model stepped at that same rising edge. Non-strobe cycles are checked for unchanged outputs at the same point. This makes every result due exactly one edge after the stimulus that caused it.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
   typedef enum logic [1:0] {
      SPR_W64  = 2'b00,
      SPR_W32  = 2'b01,
      SPR_PAIR = 2'b10,
      SPR_RSV  = 2'b11
   } spread_mode_e;
endpackage

// File: rtl/dsss_chip_sel.sv
module dsss_chip_sel
   import dsss_pkg::*;
#(
   parameter int CODE_W = 64,
   localparam int IW    = $clog2(CODE_W),
   localparam int HALF  = CODE_W / 2
) (
   input  logic [CODE_W-1:0] code,
   input  spread_mode_e      mode,
   input  logic [1:0]        sym,
   input  logic [IW-1:0]     idx,
   output logic              chip
);
   logic [CODE_W-1:0] rev;
   logic [IW-1:0]     lo_idx;
   logic              raw;

   // rev[k] is the k-th chip on air (most significant code bit first)
   for (genvar g = 0; g < CODE_W; g++) begin : g_rev
      assign rev[g] = code[CODE_W-1-g];
   end

   assign lo_idx = idx | IW'(HALF);

   always_comb begin
      unique case (mode)
         SPR_PAIR: raw = sym[1] ? rev[idx] : rev[lo_idx];
         default:  raw = rev[idx];
      endcase
      chip = sym[0] ? raw : ~raw;
   end
endmodule

// File: rtl/dsss_seq.sv
module dsss_seq
   import dsss_pkg::*;
#(
   parameter int CODE_W = 64,
   localparam int IW    = $clog2(CODE_W),
   localparam int HALF  = CODE_W / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chip_en,
   input  logic          din_valid,
   input  spread_mode_e  mode_act,
   output logic          fetch,
   output logic          starve,
   output logic [IW-1:0] next_idx
);
   logic          busy;
   logic [IW-1:0] cnt;
   logic [IW-1:0] last;
   logic          boundary;

   assign last     = (mode_act == SPR_W32 || mode_act == SPR_PAIR) ? IW'(HALF - 1) : IW'(CODE_W - 1);
   assign boundary = !busy || (cnt == last);
   assign fetch    = chip_en && boundary && din_valid;
   assign starve   = chip_en && boundary && !din_valid;
   assign next_idx = fetch ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (fetch) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (starve) begin
         busy <= 1'b0;
      end else if (chip_en) begin
         cnt  <= cnt + 1'b1;
      end
   end

   // R3/R4: the counter never passes the last chip of the active symbol
   p_cnt_in_symbol_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt <= last);
   // R2: chip position moves only on a strobe
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> $stable(cnt) && $stable(busy));
   // R7: the symbol length source stays fixed between boundaries
   p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en && !boundary) |=> $stable(last));
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
   import dsss_pkg::*;
#(
   parameter int   CODE_W    = 64,
   parameter logic IDLE_CHIP = 1'b0,
   localparam int  IW        = $clog2(CODE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic [1:0]        mode,
   input  logic              din_valid,
   input  logic [1:0]        din,
   output logic              din_take,
   input  logic              code_load,
   input  logic [CODE_W-1:0] code_in,
   output logic              chip_out,
   output logic              underrun
);
   if (CODE_W < 4 || (CODE_W & (CODE_W - 1)) != 0) begin : g_bad_width
      $error("dsss_spreader: CODE_W must be a power of two of at least 4");
   end

   spread_mode_e      mode_act, sel_mode;
   logic [CODE_W-1:0] code_shadow, code_act, sel_code;
   logic [1:0]        sym, sel_sym;
   logic              fetch, starve, chip_nxt;
   logic [IW-1:0]     next_idx;

   dsss_seq #(.CODE_W(CODE_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .chip_en  (chip_en),
      .din_valid(din_valid),
      .mode_act (mode_act),
      .fetch    (fetch),
      .starve   (starve),
      .next_idx (next_idx)
   );

   assign sel_code = fetch ? code_shadow : code_act;
   assign sel_mode = fetch ? spread_mode_e'(mode) : mode_act;
   assign sel_sym  = fetch ? din : sym;

   dsss_chip_sel #(.CODE_W(CODE_W)) u_sel (
      .code(sel_code),
      .mode(sel_mode),
      .sym (sel_sym),
      .idx (next_idx),
      .chip(chip_nxt)
   );

   assign din_take = fetch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_shadow <= '0;
      else if (code_load) code_shadow <= code_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_act <= SPR_W64;
         code_act <= '0;
         sym      <= '0;
         chip_out <= 1'b0;
         underrun <= 1'b0;
      end else if (chip_en) begin
         if (fetch) begin
            mode_act <= sel_mode;
            code_act <= code_shadow;
            sym      <= din;
         end
         chip_out <= starve ? IDLE_CHIP : chip_nxt;
         underrun <= starve;
      end
   end

   // R6: data is consumed only on a strobe with data offered
   p_take_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      din_take |-> (chip_en && din_valid));
   // R9: idle chips while starved
   p_idle_chip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (chip_out == IDLE_CHIP));
   // R2: outputs move only on a strobe
   p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> $stable(chip_out) && $stable(underrun));
   // R8: a running symbol keeps its code
   p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch |=> $stable(code_act));
endmodule

// File: tb/tb_dsss_spreader.sv
module tb_dsss_spreader;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chip_en = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          din_valid = 1'b0;
   logic [1:0]    din = 2'b00;
   logic          din_take;
   logic          code_load = 1'b0;
   logic [CW-1:0] code_in = '0;
   logic          chip_out;
   logic          underrun;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   bit            m_busy = 0;
   int            m_cnt = 0;
   logic [1:0]    m_mode = 2'b00;
   logic [CW-1:0] m_code = '0, m_shadow = '0;
   logic [1:0]    m_sym = 2'b00;
   logic          e_chip = 0, e_und = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsss_spreader dut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .mode(mode),
      .din_valid(din_valid), .din(din), .din_take(din_take),
      .code_load(code_load), .code_in(code_in),
      .chip_out(chip_out), .underrun(underrun)
   );

   function automatic int sym_len(logic [1:0] md);
      return (md == 2'b01 || md == 2'b10) ? CW/2 : CW;
   endfunction

   // expected chip from R3/R4/R5
   function automatic logic exp_chip(logic [CW-1:0] code, logic [1:0] md,
                                     logic [1:0] s, int idx);
      logic r;
      if (md == 2'b10 && !s[1]) r = code[CW/2-1-idx];
      else                      r = code[CW-1-idx];
      return s[0] ? r : ~r;
   endfunction

   function automatic string req_of(logic [1:0] md);
      return (md == 2'b01) ? "R4" : (md == 2'b10) ? "R5" : "R3";
   endfunction

   task automatic check(string req, logic act, logic expv, string what);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, expv, $time);
      end
   endtask

   task automatic run(int n, int en_pct, int val_pct, int mode_sel, int load_pct);
      for (int i = 0; i < n; i++) begin
         bit bnd, exp_take;
         chip_en   = ($urandom % 100) < en_pct;
         din_valid = ($urandom % 100) < val_pct;
         din       = 2'($urandom);
         mode      = (mode_sel < 0) ? 2'($urandom) : 2'(mode_sel);
         code_load = ($urandom % 100) < load_pct;
         code_in   = {$urandom, $urandom};
         #1;
         bnd = !m_busy || (m_cnt == sym_len(m_mode) - 1);
         exp_take = chip_en && bnd && din_valid;
         check("R6", din_take, exp_take, "din_take");
         @(posedge clk);
         if (chip_en) begin
            if (bnd) begin
               if (din_valid) begin
                  m_mode = mode; m_code = m_shadow; m_sym = din;
                  m_cnt = 0; m_busy = 1;
                  e_chip = exp_chip(m_code, m_mode, m_sym, 0); e_und = 0;
               end else begin
                  m_busy = 0; e_chip = 1'b0; e_und = 1;
               end
            end else begin
               m_cnt++;
               e_chip = exp_chip(m_code, m_mode, m_sym, m_cnt); e_und = 0;
            end
         end
         if (code_load) m_shadow = code_in;   // R8 shadow write
         @(negedge clk);
         if (!chip_en) begin
            check("R2", chip_out, e_chip, "chip_out held");
            check("R2", underrun, e_und, "underrun held");
         end else if (e_und) begin
            check("R9", chip_out, 1'b0, "idle chip");
            check("R9", underrun, 1'b1, "underrun");
         end else begin
            check(req_of(m_mode), chip_out, e_chip, "chip_out");
            check("R9", underrun, 1'b0, "underrun clear");
         end
      end
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", chip_out, 1'b0, "reset chip_out");
      check("R1", underrun, 1'b0, "reset underrun");
      check("R1", din_take, 1'b0, "reset din_take");
      rst_n = 1'b1;
      // first code load, no strobes yet (R8)
      run(2, 0, 0, 0, 100);
      // R3: 64-chip mode, dense strobes
      run(3000, 90, 95, 0, 0);
      // R4: 32-chip mode
      run(2000, 70, 95, 1, 2);
      // R5: paired mode
      run(2000, 80, 95, 2, 2);
      // R9: starve at boundaries, then recover
      run(300, 100, 0, 2, 0);
      run(600, 100, 50, 0, 0);
      // R7/R8: mode and code change every cycle, all four encodings
      run(4000, 60, 90, -1, 30);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule